// File: doc/BRIEF.md
# Whole-Line Write Coverage Detector

This block watches the stream of requests that are merged into a single outstanding miss entry. It decides whether every one of those requests is a plain, mergeable write, and whether together they write every byte of the cache line. When both hold, the miss can go out as a full-line write, and the line does not have to be fetched from below. The block keeps one coverage bit per byte of the line. A sticky only-writes flag gates that bitmap: the first request that is not a plain write drops the flag for good, and the bitmap then stops changing.

A controller pulses `init_i` when the entry is allocated. It presents each request with `req_valid_i`, and pulses `issue_i` when the miss leaves. At that point the live whole-line result is captured in `was_whole_line_o`. Requests that arrive later may change the live result, but they cannot change the captured one.

The control is a three-state machine. COLLECT is the reset and post-init state: only-writes is true and coverage is partial. A mergeable request whose bytes complete the line moves COLLECT to COVERED (transition *complete*). A non-mergeable request moves COLLECT to REJECTED (transition *disqualify*). COVERED and REJECTED hold until the next init, which returns any state to COLLECT (transition *restart*). A mergeable request that leaves the line incomplete stays in COLLECT (transition *accumulate*).

Top module: `line_write_cover`

## Requirements
- R1: After reset, only_writes_o is 1, cover_map_o is all zero, and whole_line_o and was_whole_line_o are 0.
- R2: A cycle with init_i high sets only_writes_o to 1 and clears cover_map_o and was_whole_line_o from the next cycle on. A request or an issue in that same cycle is ignored.
- R3: A request is mergeable only if req_is_write_i is 1 and all eight bits of req_attr_i are 0. Any set bit marks one of: uncacheable, strict ordering, internal register access, privileged, exclusive-pair access, swap, conditional swap, secure. A non-mergeable request clears only_writes_o from the next cycle until the next init.
- R4: A mergeable request taken while only_writes_o is 1 and the line is not yet covered sets cover_map_o bits offset through offset+size-1. Bit i stands for byte i. Bytes past 63 are clipped, and size 0 sets no bit.
- R5: While only_writes_o is 0, requests leave cover_map_o unchanged.
- R6: Once the line is fully covered, further requests of any kind change neither only_writes_o nor cover_map_o.
- R7: whole_line_o equals only_writes_o AND all bits of cover_map_o. It rises in the cycle after the request that completes coverage.
- R8: When issue_i is high, was_whole_line_o takes the whole_line_o value of that cycle on the next edge, and holds it until the next issue or init.
- R9: Between inits, a cover_map_o bit that is set never clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Start tracking a newly allocated entry |
| issue_i | input | 1 | Miss is being sent; capture the live result |
| req_valid_i | input | 1 | A request is merged this cycle |
| req_is_write_i | input | 1 | Request is a write |
| req_offset_i | input | 6 | First byte of the request within the line |
| req_size_i | input | 7 | Byte count of the request (0 to 64) |
| req_attr_i | input | 8 | Attribute bits; any set bit forbids merging |
| only_writes_o | output | 1 | All requests so far were mergeable writes |
| cover_map_o | output | 64 | Per-byte written map |
| whole_line_o | output | 1 | Live full-line-write indication |
| was_whole_line_o | output | 1 | Result captured at issue |

## Verification
The detector is driven with several kinds of write sequence. Disjoint partial writes show that coverage accumulates. A write running past the line end tests the clipping, and a zero-byte write tests the empty case. A single 64-byte write completes the line in one step, and a stream of aligned 8-byte writes in scrambled order arrives at coverage only through the union. After coverage, reads and attributed writes are sent to confirm the freeze. Separate sequences put a read, or a write with one attribute bit set, in the middle of partial writes; these tell a sticky disqualification apart from a flag that recovers. Issue pulses in covered and rejected states, and an init in the same cycle as a request or an issue, separate the captured status from the live one.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
    localparam int ATTR_W = 8;

    typedef enum logic [1:0] {
        ST_COLLECT  = 2'd0,
        ST_COVERED  = 2'd1,
        ST_REJECTED = 2'd2
    } lwc_state_e;
endpackage

// File: rtl/lwc_byte_mask.sv
module lwc_byte_mask #(
    parameter int LINE_BYTES = 64,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int SIZE_W     = OFF_W + 1
) (
    input  logic [OFF_W-1:0]      offset_i,
    input  logic [SIZE_W-1:0]     size_i,
    output logic [LINE_BYTES-1:0] mask_o
);
    localparam int END_W = SIZE_W + 1;

    logic [END_W-1:0] start_w;
    logic [END_W-1:0] stop_w;

    assign start_w = {{(END_W-OFF_W){1'b0}}, offset_i};
    assign stop_w  = start_w + {1'b0, size_i};

    // One comparator pair per byte; bytes past the line never exist, so
    // a span running off the end is clipped implicitly.
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign mask_o[b] = (END_W'(b) >= start_w) && (END_W'(b) < stop_w);
    end
endmodule

// File: rtl/lwc_merge_qual.sv
module lwc_merge_qual #(
    parameter int ATTR_W = lwc_pkg::ATTR_W
) (
    input  logic              is_write_i,
    input  logic [ATTR_W-1:0] attr_i,
    output logic              mergeable_o
);
    assign mergeable_o = is_write_i && (attr_i == '0);
endmodule

// File: rtl/lwc_issue_latch.sv
module lwc_issue_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic issue_i,
    input  logic whole_i,
    output logic was_whole_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            was_whole_o <= 1'b0;
        end else if (init_i) begin
            was_whole_o <= 1'b0;
        end else if (issue_i) begin
            was_whole_o <= whole_i;
        end
    end
endmodule

// File: rtl/line_write_cover.sv
module line_write_cover
    import lwc_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int SIZE_W     = OFF_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_i,
    input  logic                  issue_i,
    input  logic                  req_valid_i,
    input  logic                  req_is_write_i,
    input  logic [OFF_W-1:0]      req_offset_i,
    input  logic [SIZE_W-1:0]     req_size_i,
    input  logic [ATTR_W-1:0]     req_attr_i,
    output logic                  only_writes_o,
    output logic [LINE_BYTES-1:0] cover_map_o,
    output logic                  whole_line_o,
    output logic                  was_whole_line_o
);
    lwc_state_e            state_q, state_d;
    logic [LINE_BYTES-1:0] map_q, map_d;
    logic [LINE_BYTES-1:0] req_mask;
    logic [LINE_BYTES-1:0] merged_map;
    logic                  mergeable;

    lwc_byte_mask #(
        .LINE_BYTES(LINE_BYTES),
        .OFF_W     (OFF_W),
        .SIZE_W    (SIZE_W)
    ) u_mask (
        .offset_i(req_offset_i),
        .size_i  (req_size_i),
        .mask_o  (req_mask)
    );

    lwc_merge_qual #(
        .ATTR_W(ATTR_W)
    ) u_qual (
        .is_write_i (req_is_write_i),
        .attr_i     (req_attr_i),
        .mergeable_o(mergeable)
    );

    assign merged_map = map_q | req_mask;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
            map_q   <= '0;
        end else begin
            state_q <= state_d;
            map_q   <= map_d;
        end
    end

    // Next state: restart / accumulate / complete / disqualify
    always_comb begin
        state_d = state_q;
        map_d   = map_q;
        if (init_i) begin
            state_d = ST_COLLECT;
            map_d   = '0;
        end else if (req_valid_i) begin
            unique case (state_q)
                ST_COLLECT: begin
                    if (!mergeable) begin
                        state_d = ST_REJECTED;
                    end else begin
                        map_d = merged_map;
                        if (&merged_map) begin
                            state_d = ST_COVERED;
                        end
                    end
                end
                ST_COVERED:  state_d = ST_COVERED;
                ST_REJECTED: state_d = ST_REJECTED;
                default:     state_d = ST_COLLECT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        only_writes_o = (state_q != ST_REJECTED);
        whole_line_o  = (state_q == ST_COVERED);
        cover_map_o   = map_q;
    end

    lwc_issue_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .issue_i    (issue_i),
        .whole_i    (whole_line_o),
        .was_whole_o(was_whole_line_o)
    );
endmodule

// File: rtl/lwc_checker.sv
module lwc_checker #(
    parameter int LINE_BYTES = 64,
    parameter int ATTR_W     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  init_i,
    input logic                  issue_i,
    input logic                  req_valid_i,
    input logic                  req_is_write_i,
    input logic [ATTR_W-1:0]     req_attr_i,
    input logic                  only_writes_o,
    input logic [LINE_BYTES-1:0] cover_map_o,
    input logic                  whole_line_o,
    input logic                  was_whole_line_o
);
    assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (only_writes_o && (cover_map_o == '0) && !was_whole_line_o));

    assert_disqualify_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !init_i && only_writes_o && !whole_line_o &&
         (!req_is_write_i || (req_attr_i != '0))) |=> !only_writes_o);

    assert_reject_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!only_writes_o && !init_i) |=> (!only_writes_o && $stable(cover_map_o)));

    assert_cover_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (whole_line_o && !init_i) |=> (only_writes_o && $stable(cover_map_o)));

    assert_whole_def_R7: assert property (@(posedge clk) disable iff (!rst_n)
        whole_line_o == (only_writes_o && (&cover_map_o)));

    assert_issue_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !init_i) |=> (was_whole_line_o == $past(whole_line_o)));

    assert_map_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> ((cover_map_o & $past(cover_map_o)) == $past(cover_map_o)));
endmodule

bind line_write_cover lwc_checker #(
    .LINE_BYTES(LINE_BYTES),
    .ATTR_W    (lwc_pkg::ATTR_W)
) u_lwc_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .init_i          (init_i),
    .issue_i         (issue_i),
    .req_valid_i     (req_valid_i),
    .req_is_write_i  (req_is_write_i),
    .req_attr_i      (req_attr_i),
    .only_writes_o   (only_writes_o),
    .cover_map_o     (cover_map_o),
    .whole_line_o    (whole_line_o),
    .was_whole_line_o(was_whole_line_o)
);

// File: tb/line_write_cover_bench.sv
`timescale 1ns/1ps
module line_write_cover_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic        issue_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_is_write_i = 1'b0;
    logic [5:0]  req_offset_i = '0;
    logic [6:0]  req_size_i = '0;
    logic [7:0]  req_attr_i = '0;
    logic        only_writes_o;
    logic [63:0] cover_map_o;
    logic        whole_line_o;
    logic        was_whole_line_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // Behavioural reference
    bit          m_ow;
    bit [63:0]   m_map;
    bit          m_was;

    always #2.5 clk = ~clk;

    line_write_cover u_line_write_cover (
        .clk             (clk),
        .rst_n           (rst_n),
        .init_i          (init_i),
        .issue_i         (issue_i),
        .req_valid_i     (req_valid_i),
        .req_is_write_i  (req_is_write_i),
        .req_offset_i    (req_offset_i),
        .req_size_i      (req_size_i),
        .req_attr_i      (req_attr_i),
        .only_writes_o   (only_writes_o),
        .cover_map_o     (cover_map_o),
        .whole_line_o    (whole_line_o),
        .was_whole_line_o(was_whole_line_o)
    );

    function automatic bit m_whole();
        return m_ow && (m_map == {64{1'b1}});
    endfunction

    task automatic compare(input string tag);
        bit [66:0] act, exp;
        act = {only_writes_o, whole_line_o, was_whole_line_o, cover_map_o};
        exp = {m_ow, m_whole(), m_was, m_map};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual ow/whole/was/map=%0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
                     tag, act[66], act[65], act[64], act[63:0],
                     exp[66], exp[65], exp[64], exp[63:0]);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, update the model
    // after the rising edge, compare at the next falling edge.
    task automatic step(input bit init, input bit issue, input bit valid,
                        input bit wr, input int off, input int sz,
                        input bit [7:0] attr, input string tag);
        bit pre_whole;
        init_i         = init;
        issue_i        = issue;
        req_valid_i    = valid;
        req_is_write_i = wr;
        req_offset_i   = 6'(off);
        req_size_i     = 7'(sz);
        req_attr_i     = attr;
        @(posedge clk);
        pre_whole = m_whole();
        if (init) begin
            m_ow  = 1'b1;
            m_map = '0;
            m_was = 1'b0;
        end else begin
            if (issue) m_was = pre_whole;
            if (valid && !pre_whole) begin
                m_ow = m_ow && wr && (attr == 8'h00);
                if (m_ow) begin
                    for (int i = off; i < off + sz; i++) begin
                        if (i < 64) m_map[i] = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        init_i      = 1'b0;
        issue_i     = 1'b0;
        req_valid_i = 1'b0;
        compare(tag);
    endtask

    task automatic wr(input int off, input int sz, input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b1, off, sz, 8'h00, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 8'h00, tag);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        m_ow = 1'b1; m_map = '0; m_was = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset state");
        idle("R1 idle after reset");

        // Partial writes accumulate, clipping and empty size
        step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 8'h00, "R2 init");
        wr(0, 4, "R4 first span");
        wr(16, 8, "R4 disjoint span");
        wr(2, 10, "R9 overlapping span");
        wr(60, 16, "R4 clipped at line end");
        wr(30, 0, "R4 size zero");
        wr(12, 4, "R4 fill 12..15");
        wr(24, 36, "R7 completing span");
        idle("R7 whole holds");
        step(1'b0, 1'b0, 1'b1, 1'b0, 0, 8, 8'h00, "R6 read after cover");
        step(1'b0, 1'b0, 1'b1, 1'b1, 0, 8, 8'h04, "R6 attr write after cover");
        step(1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 8'h00, "R8 issue when covered");
        idle("R8 was holds");

        // Read mid-stream disqualifies permanently
        step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 8'h00, "R2 init clears was");
        wr(0, 32, "R4 half line");
        step(1'b0, 1'b0, 1'b1, 1'b0, 40, 4, 8'h00, "R3 read disqualifies");
        wr(32, 32, "R5 write after reject frozen");
        step(1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 8'h00, "R8 issue when rejected");

        // Each attribute bit disqualifies a write
        for (int a = 0; a < 8; a++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 8'h00, "R2 init");
            wr(8, 8, "R4 before attr");
            step(1'b0, 1'b0, 1'b1, 1'b1, 0, 8, 8'(1 << a), "R3 attribute write");
            wr(0, 64, "R5 frozen after attr");
        end

        // Init wins over a request and an issue in the same cycle
        step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 8'h00, "R2 init");
        wr(0, 64, "R7 one full write");
        step(1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 8'h00, "R8 capture");
        step(1'b1, 1'b1, 1'b1, 1'b1, 0, 16, 8'h00, "R2 init beats req and issue");
        step(1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 8'h00, "R8 issue while partial");

        // Scrambled aligned 8-byte chunks
        step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 8'h00, "R2 init");
        seed = 32'h1d;
        for (int k = 0; k < 60 && !m_whole(); k++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            wr(((seed >> 8) % 8) * 8, 8, "R7 scrambled chunks");
        end
        step(1'b0, 1'b1, 1'b1, 1'b0, 0, 4, 8'h00, "R6 R8 issue with read");
        idle("R8 final hold");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule